// File: doc/BRIEF.md
# Write-only two-wire control register target

This block is a write-only target on a two-wire serial control bus, placed in front of the control registers of an audio mixer and amplifier. It samples the bus clock and data lines into the system clock domain and finds start and stop conditions. It then compares the first byte of each transfer against a 7-bit device address. The lowest bit of that address comes from a strap input. The block acknowledges a matching write by pulling the data line low. After that, every data byte routes itself: its two top bits name one of four 6-bit registers, and its low six bits are stored into that register. No sub-address byte is used, so any number of bytes may follow one address byte until a stop arrives.

The registers hold the mono gain code, the left and right gain codes, the two stereo-widening enables, the output mixer mode and the wake-up speed select. The data line is driven as open drain, so the block only asserts a pull-low enable.

The link controller has six named states:
- IDLE waits for a start.
- ADDR shifts in the address byte.
- ADDR_ACK holds the acknowledge for the address.
- DATA shifts in a data byte.
- DATA_ACK holds the acknowledge for a data byte and commits the byte.
- SKIP ignores the bus until the next start or stop.

The transitions are:
- A start moves any state to ADDR.
- A stop moves any state to IDLE.
- ADDR goes to ADDR_ACK on a match, or to SKIP on a mismatch, at the SCL falling edge after the eighth bit.
- ADDR_ACK goes to DATA, and DATA_ACK goes back to DATA, at the falling edge that ends the acknowledge pulse.
- DATA goes to DATA_ACK at the falling edge after its eighth bit.

Top module: `mixctl_i2c_target`

## Requirements
- R1: After the asynchronous reset every register output reads zero and the data line is released (`sda_drive_low_o` = 0).
- R2: SDA falling while SCL is high is a start. SDA rising while SCL is high is a stop. A start in the middle of a transfer, including partway through a data byte, returns the block to the address phase, and a following matching address is acknowledged.
- R3: Bits are sampled on SCL rising edges, most significant bit first. The address byte that matches is 1111_10S0, where S is the level of `addr_sel_i`.
- R4: For a matching write address the block pulls SDA low for the whole ninth clock pulse. For a mismatching address, or for the matching address with R/W = 1, it leaves SDA released and ignores all bytes until the next start or stop.
- R5: Every data byte after an acknowledged address is acknowledged in the same way, for any number of bytes up to the stop.
- R6: Data bits 7:6 select the target register: 00 mono, 01 left, 10 right, 11 mode.
- R7: In a mono byte, bits 4:0 become `mono_gain_o`. Bit 5 has no effect on any output.
- R8: In a left byte, bits 4:0 become `left_gain_o` and bit 5 becomes `spk_wide_o`. In a right byte, bits 4:0 become `right_gain_o` and bit 5 becomes `hp_wide_o`.
- R9: In a mode byte, bits 3:0 become `out_mode_o` and bit 5 becomes `slow_wake_o`. Bit 4 has no effect on any output.
- R10: A data byte cut short by a start or a stop, even after all eight bits were sampled, leaves every register unchanged.
- R11: Register outputs change only on the cycle after a complete data byte has been received, and that byte is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| addr_sel_i | input | 1 | Strap that sets address bit 0 |
| sda_drive_low_o | output | 1 | Open-drain pull-low enable for SDA |
| mono_gain_o | output | 5 | Mono gain code |
| left_gain_o | output | 5 | Left gain code |
| right_gain_o | output | 5 | Right gain code |
| spk_wide_o | output | 1 | Loudspeaker widening enable |
| hp_wide_o | output | 1 | Headphone widening enable |
| out_mode_o | output | 4 | Output mixer mode |
| slow_wake_o | output | 1 | Wake-up select: 0 fast, 1 slow |

## Verification
Two functions can fall on the same system cycle. The first is the register commit, which fires on the SCL falling edge that follows a data byte's eighth bit. The second is the acknowledge pull-low, which begins on that same edge. The checker requires the pull-low to follow every commit, and the bench reads back each acknowledge at both ends of the ninth pulse.

A harder overlap is a start that arrives after the eighth data bit has been sampled but before the falling edge that would commit it. The bench provokes this by cutting a byte after seven bits and then issuing a repeated start, whose SCL rise samples the eighth bit. It judges the result by confirming that no register moved and that the next address is still acknowledged.

// File: rtl/mixctl_pkg.sv
package mixctl_pkg;
    localparam int BYTE_W  = 8;
    localparam int TAG_W   = 2;
    localparam int FIELD_W = BYTE_W - TAG_W;
    localparam int NUM_REGS = 1 << TAG_W;
    localparam int GAIN_W  = 5;
    localparam int MODE_W  = 4;
    localparam int CNT_W   = $clog2(BYTE_W + 1);
    localparam logic [BYTE_W-3:0] ADDR_HI = 6'b111110;

    localparam logic [TAG_W-1:0] TAG_MONO  = 2'd0;
    localparam logic [TAG_W-1:0] TAG_LEFT  = 2'd1;
    localparam logic [TAG_W-1:0] TAG_RIGHT = 2'd2;
    localparam logic [TAG_W-1:0] TAG_MODE  = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_SKIP
    } link_state_t;
endpackage

// File: rtl/mixctl_sync.sv
module mixctl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] lvl;
    logic [LINES-1:0] lvl_q;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] pipe;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe     <= '1;
                lvl_q[g] <= 1'b1;
            end else begin
                pipe     <= {pipe[STAGES-2:0], raw[g]};
                lvl_q[g] <= pipe[STAGES-1];
            end
        end
        assign lvl[g] = pipe[STAGES-1];
    end

    assign scl_lvl   = lvl[0];
    assign sda_lvl   = lvl[1];
    assign scl_rise  = lvl[0] & ~lvl_q[0];
    assign scl_fall  = ~lvl[0] & lvl_q[0];
    assign start_det = lvl[0] & lvl_q[0] & lvl_q[1] & ~lvl[1];
    assign stop_det  = lvl[0] & lvl_q[0] & ~lvl_q[1] & lvl[1];
endmodule

// File: rtl/mixctl_link.sv
module mixctl_link
    import mixctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_sel,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    output link_state_t       state,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_byte,
    output logic              sda_drive_low
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

    link_state_t       state_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic [BYTE_W-1:0] shreg, shreg_n;
    logic              addr_hit;
    logic              byte_done;

    assign addr_hit  = (shreg == {ADDR_HI, addr_sel, 1'b0});
    assign byte_done = scl_fall && (cnt == CNT_FULL);

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        shreg_n = shreg;
        if (start_det) begin
            state_n = ST_ADDR;
            cnt_n   = '0;
        end else if (stop_det) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_ADDR, ST_DATA: begin
                    if (scl_rise && cnt != CNT_FULL) begin
                        shreg_n = {shreg[BYTE_W-2:0], sda_lvl};
                        cnt_n   = cnt + CNT_W'(1);
                    end else if (byte_done) begin
                        if (state == ST_ADDR)
                            state_n = addr_hit ? ST_ADDR_ACK : ST_SKIP;
                        else
                            state_n = ST_DATA_ACK;
                    end
                end
                ST_ADDR_ACK, ST_DATA_ACK: begin
                    if (scl_fall) begin
                        state_n = ST_DATA;
                        cnt_n   = '0;
                    end
                end
                ST_SKIP: ;
                default: state_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            shreg <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            shreg <= shreg_n;
        end
    end

    always_comb begin
        sda_drive_low = (state == ST_ADDR_ACK) || (state == ST_DATA_ACK);
        wr_en         = (state == ST_DATA) && byte_done && !start_det && !stop_det;
        wr_byte       = shreg;
    end
endmodule

// File: rtl/mixctl_regbank.sv
module mixctl_regbank
    import mixctl_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [BYTE_W-1:0]                 wr_byte,
    output logic [NUM_REGS-1:0][FIELD_W-1:0]  regs
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[i] <= '0;
            else if (wr_en && wr_byte[BYTE_W-1 -: TAG_W] == TAG_W'(i))
                regs[i] <= wr_byte[FIELD_W-1:0];
        end
    end
endmodule

// File: rtl/mixctl_i2c_target.sv
module mixctl_i2c_target
    import mixctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              addr_sel_i,
    output logic              sda_drive_low_o,
    output logic [GAIN_W-1:0] mono_gain_o,
    output logic [GAIN_W-1:0] left_gain_o,
    output logic [GAIN_W-1:0] right_gain_o,
    output logic              spk_wide_o,
    output logic              hp_wide_o,
    output logic [MODE_W-1:0] out_mode_o,
    output logic              slow_wake_o
);
    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    link_state_t link_state;
    logic wr_en;
    logic [BYTE_W-1:0] wr_byte;
    logic [NUM_REGS-1:0][FIELD_W-1:0] regs;
    logic unused_bits;

    mixctl_sync #(.STAGES(2)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    mixctl_link u_link (
        .clk           (clk),
        .rst_n         (rst_n),
        .addr_sel      (addr_sel_i),
        .sda_lvl       (sda_lvl),
        .scl_rise      (scl_rise),
        .scl_fall      (scl_fall),
        .start_det     (start_det),
        .stop_det      (stop_det),
        .state         (link_state),
        .wr_en         (wr_en),
        .wr_byte       (wr_byte),
        .sda_drive_low (sda_drive_low_o)
    );

    mixctl_regbank u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_byte (wr_byte),
        .regs    (regs)
    );

    assign mono_gain_o  = regs[TAG_MONO][GAIN_W-1:0];
    assign left_gain_o  = regs[TAG_LEFT][GAIN_W-1:0];
    assign spk_wide_o   = regs[TAG_LEFT][FIELD_W-1];
    assign right_gain_o = regs[TAG_RIGHT][GAIN_W-1:0];
    assign hp_wide_o    = regs[TAG_RIGHT][FIELD_W-1];
    assign out_mode_o   = regs[TAG_MODE][MODE_W-1:0];
    assign slow_wake_o  = regs[TAG_MODE][FIELD_W-1];
    assign unused_bits  = ^{regs[TAG_MONO][FIELD_W-1], regs[TAG_MODE][MODE_W], scl_lvl};
endmodule

// File: rtl/mixctl_checker.sv
module mixctl_checker
    import mixctl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              scl_lvl,
    input logic              start_det,
    input logic              stop_det,
    input logic              wr_en,
    input link_state_t       state,
    input logic              sda_drive_low_o,
    input logic [GAIN_W-1:0] mono_gain_o,
    input logic [GAIN_W-1:0] left_gain_o,
    input logic [GAIN_W-1:0] right_gain_o,
    input logic              spk_wide_o,
    input logic              hp_wide_o,
    input logic [MODE_W-1:0] out_mode_o,
    input logic              slow_wake_o
);
    p_ack_begins_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive_low_o) |-> !scl_lvl);

    p_ack_ends_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_drive_low_o) |-> (!scl_lvl || $past(stop_det)));

    p_start_to_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> state == ST_ADDR);

    p_stop_to_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE && !sda_drive_low_o));

    p_commit_acked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> sda_drive_low_o);

    p_hold_regs_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable({mono_gain_o, left_gain_o, right_gain_o, spk_wide_o,
                            hp_wide_o, out_mode_o, slow_wake_o}));
endmodule

bind mixctl_i2c_target mixctl_checker u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .scl_lvl         (scl_lvl),
    .start_det       (start_det),
    .stop_det        (stop_det),
    .wr_en           (wr_en),
    .state           (link_state),
    .sda_drive_low_o (sda_drive_low_o),
    .mono_gain_o     (mono_gain_o),
    .left_gain_o     (left_gain_o),
    .right_gain_o    (right_gain_o),
    .spk_wide_o      (spk_wide_o),
    .hp_wide_o       (hp_wide_o),
    .out_mode_o      (out_mode_o),
    .slow_wake_o     (slow_wake_o)
);

// File: tb/mixctl_i2c_target_test.sv
module mixctl_i2c_target_test;
    localparam int HALF = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic strap = 1'b0;
    logic sda_bus;

    logic       sda_drive_low_o;
    logic [4:0] mono_gain_o, left_gain_o, right_gain_o;
    logic       spk_wide_o, hp_wide_o, slow_wake_o;
    logic [3:0] out_mode_o;

    int n_checks = 0;
    int n_err = 0;
    logic [5:0] m_reg [4];

    always #4 clk = ~clk;

    assign sda_bus = m_sda & ~sda_drive_low_o;

    mixctl_i2c_target uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .scl_i           (m_scl),
        .sda_i           (sda_bus),
        .addr_sel_i      (strap),
        .sda_drive_low_o (sda_drive_low_o),
        .mono_gain_o     (mono_gain_o),
        .left_gain_o     (left_gain_o),
        .right_gain_o    (right_gain_o),
        .spk_wide_o      (spk_wide_o),
        .hp_wide_o       (hp_wide_o),
        .out_mode_o      (out_mode_o),
        .slow_wake_o     (slow_wake_o)
    );

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic i2c_start();
        m_sda = 1'b1; wait_clks(HALF);
        m_scl = 1'b1; wait_clks(HALF);
        m_sda = 1'b0; wait_clks(HALF);
        m_scl = 1'b0; wait_clks(4);
    endtask

    task automatic i2c_stop();
        m_sda = 1'b0; wait_clks(HALF);
        m_scl = 1'b1; wait_clks(HALF);
        m_sda = 1'b1; wait_clks(HALF);
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            m_sda = v[7-i];
            wait_clks(HALF);
            m_scl = 1'b1;
            wait_clks(HALF);
            m_scl = 1'b0;
            wait_clks(4);
        end
    endtask

    task automatic xfer_byte(input logic [7:0] v, output logic acked);
        logic early, late;
        send_bits(v, 8);
        m_sda = 1'b1;
        wait_clks(HALF);
        m_scl = 1'b1;
        wait_clks(2);
        early = sda_bus;
        wait_clks(HALF - 3);
        late = sda_bus;
        m_scl = 1'b0;
        wait_clks(4);
        acked = !early && !late;
    endtask

    function automatic void model_write(input logic [7:0] b);
        m_reg[b[7:6]] = b[5:0];
    endfunction

    task automatic check_outputs(input string req);
        check({req, " mono"},  {27'd0, mono_gain_o},  {27'd0, m_reg[0][4:0]});
        check({req, " left"},  {27'd0, left_gain_o},  {27'd0, m_reg[1][4:0]});
        check({req, " spkw"},  {31'd0, spk_wide_o},   {31'd0, m_reg[1][5]});
        check({req, " right"}, {27'd0, right_gain_o}, {27'd0, m_reg[2][4:0]});
        check({req, " hpw"},   {31'd0, hp_wide_o},    {31'd0, m_reg[2][5]});
        check({req, " mode"},  {28'd0, out_mode_o},   {28'd0, m_reg[3][3:0]});
        check({req, " wake"},  {31'd0, slow_wake_o},  {31'd0, m_reg[3][5]});
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic ack;
        logic [7:0] a, d;
        logic good;
        int nb;
        void'($urandom(32'd4242));
        for (int i = 0; i < 4; i++) m_reg[i] = 6'd0;

        // R1: reset state
        wait_clks(10);
        check_outputs("R1 reset");
        check("R1 sda released", {31'd0, sda_drive_low_o}, 32'd0);
        rst_n = 1'b1;
        wait_clks(10);

        // R3 R5 R6 R7 R8 R9: one address, four self-routed bytes
        i2c_start();
        xfer_byte(8'hF8, ack); check("R3 addr strap0 acked", {31'd0, ack}, 32'd1);
        xfer_byte(8'b00_1_10101, ack); check("R5 data ack mono", {31'd0, ack}, 32'd1);
        model_write(8'b00_1_10101);
        xfer_byte(8'b01_1_11011, ack); check("R5 data ack left", {31'd0, ack}, 32'd1);
        model_write(8'b01_1_11011);
        xfer_byte(8'b10_0_00111, ack); check("R5 data ack right", {31'd0, ack}, 32'd1);
        model_write(8'b10_0_00111);
        xfer_byte(8'b11_1_1_1010, ack); check("R5 data ack mode", {31'd0, ack}, 32'd1);
        model_write(8'b11_1_1_1010);
        i2c_stop();
        wait_clks(8);
        check_outputs("R6 R7 R8 R9 routing");

        // R3 R4: strap at 1, old address ignored, bytes after it ignored
        strap = 1'b1;
        wait_clks(8);
        i2c_start();
        xfer_byte(8'hF8, ack); check("R3 addr strap mismatch no ack", {31'd0, ack}, 32'd0);
        xfer_byte(8'h00, ack); check("R4 byte after mismatch no ack", {31'd0, ack}, 32'd0);
        i2c_stop();
        wait_clks(8);
        check_outputs("R4 ignored after mismatch");
        i2c_start();
        xfer_byte(8'hFA, ack); check("R3 addr strap1 acked", {31'd0, ack}, 32'd1);
        xfer_byte(8'h00, ack); check("R5 ack", {31'd0, ack}, 32'd1);
        model_write(8'h00);
        i2c_stop();
        wait_clks(8);
        check_outputs("R7 mono cleared");

        // R4: read request not acknowledged
        i2c_start();
        xfer_byte(8'hFB, ack); check("R4 read no ack", {31'd0, ack}, 32'd0);
        xfer_byte(8'h7F, ack); check("R4 byte after read no ack", {31'd0, ack}, 32'd0);
        i2c_stop();
        wait_clks(8);
        check_outputs("R4 read ignored");

        // R10: partial byte cut by stop
        i2c_start();
        xfer_byte(8'hFA, ack); check("R3 ack", {31'd0, ack}, 32'd1);
        send_bits(8'h7F, 5);
        i2c_stop();
        wait_clks(8);
        check_outputs("R10 cut by stop");

        // R10 R2: seven bits then repeated start (its SCL rise samples bit 8)
        i2c_start();
        xfer_byte(8'hFA, ack); check("R3 ack", {31'd0, ack}, 32'd1);
        send_bits(8'h7F, 7);
        i2c_start();
        wait_clks(4);
        check_outputs("R10 cut by repeated start");
        xfer_byte(8'hFA, ack); check("R2 addr after repeated start", {31'd0, ack}, 32'd1);
        xfer_byte(8'h9F, ack); check("R5 ack", {31'd0, ack}, 32'd1);
        model_write(8'h9F);
        i2c_stop();
        wait_clks(8);
        check_outputs("R2 R6 after repeated start");

        // Random transfers: R3 R4 R5 R11
        for (int t = 0; t < 40; t++) begin
            strap = 1'($urandom_range(0, 1));
            wait_clks(4);
            good = ($urandom_range(0, 4) != 0);
            if (good) a = {6'b111110, strap, 1'b0};
            else begin
                a = 8'($urandom);
                if (a == {6'b111110, strap, 1'b0}) a = a ^ 8'h04;
            end
            nb = $urandom_range(1, 4);
            i2c_start();
            xfer_byte(a, ack);
            check(good ? "R3 random addr ack" : "R4 random addr no ack",
                  {31'd0, ack}, {31'd0, good});
            for (int k = 0; k < nb; k++) begin
                d = 8'($urandom);
                xfer_byte(d, ack);
                check(good ? "R5 random data ack" : "R4 random data no ack",
                      {31'd0, ack}, {31'd0, good});
                if (good) model_write(d);
            end
            i2c_stop();
            wait_clks(8);
            check_outputs("R11 random");
        end

        finish_run();
    end
endmodule